// File: doc/BRIEF.md
# Phase-Framed SPI Byte Slave

This block is the receive-and-transmit shift unit of an SPI slave. It is clocked entirely by the system clock. The serial clock, data-in and select lines from the master are sampled through two-flop synchronizers, and every SPI edge is recognised in the system domain. The block serves all four SPI modes, set by two static inputs: `cfg_cpol` gives the idle level of the serial clock and `cfg_cpha` gives the clock phase. Data moves eight bits per byte, most significant bit first.

The clock phase also decides how a byte starts. In phase 0 the master's MSB capture happens on the very first clock edge. The slave therefore loads its transmit byte and drives the MSB as soon as it sees select fall, and every byte needs a fresh select high-to-low toggle. In phase 1 the first clock edge of a byte is itself the start signal: on that edge the slave loads its transmit byte and launches the MSB. Select may then stay low while bytes follow back to back. Each completed byte is presented on `rx_byte` together with a single-cycle `rx_valid`. The MISO driver is released whenever select is high.

The control state machine has four states:
- `ST_IDLE`: deselected.
- `ST_ARMED`: phase 1, waiting for the first edge of a byte.
- `ST_SHIFT`: bits moving.
- `ST_HOLD`: phase 0, byte done, waiting for select to rise.

Its transitions are:
- IDLE→SHIFT on a select fall in phase 0.
- IDLE→ARMED on select low in phase 1.
- ARMED→SHIFT on a leading edge.
- SHIFT→HOLD on the eighth capture in phase 0.
- SHIFT→ARMED on the eighth capture in phase 1.
- Any state→IDLE when select goes high.

Top module: `spis_byte_unit`

## Requirements
- R1: After reset, `spi_miso_oe` and `rx_valid` are 0 and `rx_byte` is 0.
- R2: A byte is eight capture edges. The first bit captured lands in `rx_byte[7]` and the first bit driven on MISO is `tx_byte[7]`.
- R3: A leading edge is the serial clock leaving its idle level: a rise when `cfg_cpol`=0 and a fall when `cfg_cpol`=1. The trailing edge is the return to idle.
- R4: With `cfg_cpha`=0, MOSI is captured on leading edges and MISO advances on trailing edges. The MSB is on MISO after select falls and before the first leading edge.
- R5: With `cfg_cpha`=0, a byte starts only on a select fall. Clock pulses sent after a completed byte while select stays low produce no `rx_valid`.
- R6: With `cfg_cpha`=1, the first leading edge of a byte loads the transmit byte and drives its MSB. MISO advances on later leading edges, and MOSI is captured on trailing edges.
- R7: With `cfg_cpha`=1, bytes may follow back to back with select held low. After the eighth capture the next leading edge starts a new byte.
- R8: While the synchronized select is high, `spi_miso_oe` is 0 and `spi_miso` is 0.
- R9: Select rising in the middle of a byte abandons it with no `rx_valid`. The next byte starts again from bit 7.
- R10: `rx_valid` is high for exactly one system clock after the eighth capture. `rx_byte` changes only in that cycle.
- R11: `tx_byte` is sampled once, at the start of each byte. Changing it in the middle of a byte does not alter the bits still to be shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level (static) |
| cfg_cpha | input | 1 | Clock phase select (static) |
| spi_sck | input | 1 | Serial clock from master (asynchronous) |
| spi_mosi | input | 1 | Serial data from master (asynchronous) |
| spi_ss_n | input | 1 | Active-low slave select (asynchronous) |
| tx_byte | input | DATA_W | Byte to send; sampled at each byte start |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | MISO driver enable |
| rx_byte | output | DATA_W | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_byte` |

## Verification
The properties assume that the serial clock runs at no more than a quarter of the system clock, so two `rx_valid` pulses can never fall on adjacent cycles. They also assume that `cfg_cpol` and `cfg_cpha` change only while select is high, and that the select check relies on the default synchronizer depth of two stages. The bench acts as a master with a half serial period of six system clocks. It changes MOSI only half a period away from the capture edge, so every sampled bit is settled. It switches mode only during long select-high gaps.

// File: rtl/spis_pkg.sv
package spis_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SHIFT,
        ST_HOLD
    } spis_state_e;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int unsigned       WIDTH   = 3,
    parameter int unsigned       STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/spis_edges.sv
module spis_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic cpha,
    input  logic sck_s,
    input  logic ss_s,
    output logic launch_evt,
    output logic sample_evt,
    output logic ss_fall
);

    logic sck_prev_q;
    logic ss_prev_q;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            ss_prev_q  <= 1'b1;
        end else begin
            sck_prev_q <= sck_s;
            ss_prev_q  <= ss_s;
        end
    end

    always_comb begin
        rise       = sck_s & ~sck_prev_q;
        fall       = ~sck_s & sck_prev_q;
        // leading edge leaves the idle level set by cpol
        lead       = cpol ? fall : rise;
        trail      = cpol ? rise : fall;
        sample_evt = cpha ? trail : lead;
        launch_evt = cpha ? lead : trail;
        ss_fall    = ss_prev_q & ~ss_s;
    end

endmodule

// File: rtl/spis_core.sv
module spis_core
    import spis_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpha,
    input  logic              ss_s,
    input  logic              ss_fall,
    input  logic              mosi_s,
    input  logic              launch_evt,
    input  logic              sample_evt,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso_bit,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    localparam int unsigned CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

    spis_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] tx_sr_q;
    logic [DATA_W-1:0] rx_sr_q;
    logic              load_now;
    logic              last_cap;

    always_comb begin
        last_cap = sample_evt && (cnt_q == LAST_CNT);
        load_now = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!ss_s && !cpha && ss_fall) begin
                    state_d  = ST_SHIFT;
                    load_now = 1'b1;
                end else if (!ss_s && cpha) begin
                    state_d  = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (ss_s) begin
                    state_d = ST_IDLE;
                end else if (launch_evt) begin
                    state_d  = ST_SHIFT;
                    load_now = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (ss_s)          state_d = ST_IDLE;
                else if (last_cap) state_d = cpha ? ST_ARMED : ST_HOLD;
            end
            ST_HOLD: begin
                if (ss_s) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            tx_sr_q  <= '0;
            rx_sr_q  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (load_now) begin
                tx_sr_q <= tx_data;
                cnt_q   <= '0;
            end else if (state_q == ST_SHIFT && !ss_s) begin
                if (sample_evt) begin
                    rx_sr_q <= {rx_sr_q[DATA_W-2:0], mosi_s};
                    if (last_cap) begin
                        rx_data  <= {rx_sr_q[DATA_W-2:0], mosi_s};
                        rx_valid <= 1'b1;
                        cnt_q    <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                if (launch_evt && cnt_q != '0) begin
                    tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
                end
            end else if (state_d != ST_SHIFT) begin
                cnt_q <= '0;
            end
        end
    end

    assign miso_bit = tx_sr_q[DATA_W-1];

endmodule

// File: rtl/spis_byte_unit.sv
module spis_byte_unit #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_ss_n,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);

    logic [2:0] pins_raw, pins_sync;
    logic       sck_sync, mosi_sync, ss_sync;
    logic       launch_evt, sample_evt, ss_fall;
    logic       miso_bit;

    assign pins_raw = {spi_sck, spi_mosi, spi_ss_n};

    spis_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pins_raw),
        .d_out (pins_sync)
    );

    assign {sck_sync, mosi_sync, ss_sync} = pins_sync;

    spis_edges edges_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpol       (cfg_cpol),
        .cpha       (cfg_cpha),
        .sck_s      (sck_sync),
        .ss_s       (ss_sync),
        .launch_evt (launch_evt),
        .sample_evt (sample_evt),
        .ss_fall    (ss_fall)
    );

    spis_core #(
        .DATA_W (DATA_W)
    ) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpha       (cfg_cpha),
        .ss_s       (ss_sync),
        .ss_fall    (ss_fall),
        .mosi_s     (mosi_sync),
        .launch_evt (launch_evt),
        .sample_evt (sample_evt),
        .tx_data    (tx_byte),
        .miso_bit   (miso_bit),
        .rx_data    (rx_byte),
        .rx_valid   (rx_valid)
    );

    assign spi_miso_oe = ~ss_sync;
    assign spi_miso    = spi_miso_oe & miso_bit;

endmodule

// File: rtl/spis_byte_unit_chk.sv
module spis_byte_unit_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_ss_n,
    input logic              ss_sync,
    input logic              spi_miso_oe,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_valid
);

    // R8 (assumes the default two synchronizer stages)
    oe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_ss_n, 2) |-> !spi_miso_oe);

    // R10
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte));

    // R9
    valid_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !$past(ss_sync));

endmodule

bind spis_byte_unit spis_byte_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_ss_n    (spi_ss_n),
    .ss_sync     (ss_sync),
    .spi_miso_oe (spi_miso_oe),
    .rx_byte     (rx_byte),
    .rx_valid    (rx_valid)
);

// File: tb/spis_byte_unit_tb_top.sv
`timescale 1ns/1ps
module spis_byte_unit_tb_top;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0;
    logic       cfg_cpha = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_ss_n = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       spi_miso;
    logic       spi_miso_oe;
    logic [7:0] rx_byte;
    logic       rx_valid;

    int checks = 0;
    int errors = 0;
    int rx_seen = 0;
    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    spis_byte_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_cpol    (cfg_cpol),
        .cfg_cpha    (cfg_cpha),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .spi_ss_n    (spi_ss_n),
        .tx_byte     (tx_byte),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock reference comparison of the receive strobe
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected rx_valid", 1, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rx_byte == e, "R2", "rx_byte", int'(rx_byte), int'(e));
            end
        end
    end

    // one byte as master; nbits < 8 gives a partial byte
    task automatic xfer(input logic [7:0] mo, input logic [7:0] mi,
                        input logic [7:0] nxt, input bit framed, input int nbits);
        string req;
        req = cfg_cpha ? "R6" : "R4";
        for (int i = 0; i < nbits; i++) begin
            if (!cfg_cpha) begin
                spi_mosi = mo[7-i];
                wait_clk(HALF);
                if (framed)
                    chk(spi_miso_oe && spi_miso == mi[7-i], req, $sformatf("miso bit %0d", 7-i),
                        int'(spi_miso), int'(mi[7-i]));
                spi_sck = ~cfg_cpol;
                if (i == 7 && framed) exp_q.push_back(mo);
                wait_clk(HALF);
                spi_sck = cfg_cpol;
            end else begin
                spi_sck  = ~cfg_cpol;
                spi_mosi = mo[7-i];
                wait_clk(HALF);
                if (framed)
                    chk(spi_miso_oe && spi_miso == mi[7-i], req, $sformatf("miso bit %0d", 7-i),
                        int'(spi_miso), int'(mi[7-i]));
                spi_sck = cfg_cpol;
                if (i == 7 && framed) exp_q.push_back(mo);
                wait_clk(HALF);
            end
            // R11: transmit input changes mid-byte
            if (i == 3) tx_byte = nxt;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        chk(!spi_miso_oe, "R1", "miso_oe after reset", int'(spi_miso_oe), 0);
        chk(!rx_valid, "R1", "rx_valid after reset", int'(rx_valid), 0);
        chk(rx_byte == 8'h00, "R1", "rx_byte after reset", int'(rx_byte), 0);
        chk(spi_miso == 1'b0, "R8", "miso while deselected", int'(spi_miso), 0);

        for (int m = 0; m < 4; m++) begin
            logic [7:0] a, b, c, d;
            int seen;
            a = 8'hA5 ^ 8'(m * 8'h3C);
            b = 8'h1E + 8'(m * 8'h11);
            c = 8'hC3 ^ 8'(m);
            d = 8'h69 + 8'(m * 8'h05);
            cfg_cpol = m[1];
            cfg_cpha = m[0];
            spi_sck  = cfg_cpol;  // R3: idle level
            wait_clk(10);

            if (!cfg_cpha) begin
                // R4, R3: framed bytes
                tx_byte = c; spi_ss_n = 1'b0;
                xfer(a, c, 8'hFF, 1'b1, 8);
                spi_ss_n = 1'b1; wait_clk(HALF);
                chk(!spi_miso_oe, "R8", "oe after select high", int'(spi_miso_oe), 0);
                tx_byte = d; spi_ss_n = 1'b0;
                xfer(b, d, 8'h00, 1'b1, 8);
                wait_clk(4);
                // R5: no re-frame, clocks ignored
                seen = rx_seen;
                xfer(c, 8'h00, 8'h00, 1'b0, 8);
                wait_clk(6);
                chk(rx_seen == seen, "R5", "rx_valid without reframe", rx_seen - seen, 0);
                spi_ss_n = 1'b1; wait_clk(HALF);
            end else begin
                // R7: back to back, select held low
                tx_byte = c; spi_ss_n = 1'b0; wait_clk(HALF);
                xfer(a, c, d, 1'b1, 8);
                xfer(b, d, a, 1'b1, 8);
                xfer(d, a, 8'h5A, 1'b1, 8);
                wait_clk(4);
                spi_ss_n = 1'b1; wait_clk(HALF);
                chk(!spi_miso_oe, "R8", "oe after select high", int'(spi_miso_oe), 0);
            end

            // R9: abort mid-byte then restart
            tx_byte = b; spi_ss_n = 1'b0; wait_clk(HALF);
            seen = rx_seen;
            xfer(d, b, b, 1'b1, 3);
            spi_ss_n = 1'b1; spi_sck = cfg_cpol; wait_clk(HALF + 4);
            chk(rx_seen == seen, "R9", "rx_valid after abort", rx_seen - seen, 0);
            chk(!spi_miso_oe, "R8", "oe after abort", int'(spi_miso_oe), 0);
            tx_byte = a; spi_ss_n = 1'b0;
            if (cfg_cpha) wait_clk(HALF);
            xfer(c, a, 8'h33, 1'b1, 8);
            wait_clk(6);
            chk(rx_seen == seen + 1, "R9", "byte after abort", rx_seen - seen, 1);
            spi_ss_n = 1'b1; wait_clk(2 * HALF);
        end

        chk(exp_q.size() == 0, "R2", "bytes not received", exp_q.size(), 0);
        finish_run();
    end

endmodule